// File: doc/BRIEF.md
# Row-Major to Page-Column Pixel Transposer

This block turns a monochrome bitmap, held one bit per pixel in row-major order, into the byte stream a page-organised display panel expects. There, every output byte carries eight vertically adjacent pixels of a single column. The block issues reads to a synchronous line-buffer memory and gathers one bit per read. For every column of every 8-row page it emits one byte on a valid/ready stream.

The region is described by a width in pixels, a top row, an exclusive bottom row and the panel height. A one-cycle start pulse captures these values. The top row is snapped down to a page boundary. The bottom row is snapped up to a page boundary and then limited to the panel height.

The memory holds the region's lines one after another. Each line is the width divided by eight, rounded up, in bytes long. The first line is the snapped top row. Column 0 of the region is bit 0 of the first byte of each line.

Top module: `pix_page_xpose`

## Requirements
- R1: In each output byte, bit k is the pixel of page row k, so the topmost row of the page lands in bit 0.
- R2: The pixel of region column j and relative row r is bit (j mod 8) of memory byte r*ceil(width/8) + floor(j/8). The relative row r counts from the snapped top row.
- R3: Bytes leave in ascending column order within a page, and pages leave in ascending order. One update produces exactly width × pages bytes, where pages is the snapped span divided by 8, rounded up.
- R4: The top row is rounded down to a multiple of 8. The exclusive bottom row is rounded up to a multiple of 8 and then clipped to the panel height.
- R5: Rows at or below the panel height inside the last page are never read (rdEn stays low). They contribute zero bits.
- R6: outLast is high together with the final byte of an update and low on every other byte. No read is issued in the cycle after that final byte is taken, unless a new start arrives.
- R7: With outReady held high, the first byte is valid 9 cycles after the start edge. Later bytes follow every 8 cycles with no gap between columns or pages. After a byte is taken, outValid is low in the next cycle.
- R8: While outValid is high and outReady is low, outData and outLast hold steady, no read is issued, and no byte is lost.
- R9: A start pulse while an update is still in progress is ignored, and the running update completes unchanged.
- R10: A zero width, or a snapped span with no rows, produces no reads and no output bytes.
- R11: After reset, outValid and rdEn are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures the region and begins an update when idle |
| rectWidth | input | COL_W | Region width in pixels |
| rectTop | input | ROW_W | First row of the region |
| rectBottom | input | ROW_W | Row just below the region (exclusive) |
| panelHeight | input | ROW_W | Number of rows on the panel |
| rdEn | output | 1 | Memory read strobe |
| rdAddr | output | COL_W+ROW_W-2 | Memory byte address |
| rdData | input | 8 | Memory data, valid one cycle after rdEn |
| outValid | output | 1 | Output byte available |
| outReady | input | 1 | Consumer takes the byte |
| outData | output | 8 | Column byte of one page |
| outLast | output | 1 | Marks the final byte of the update |

## Verification
A wrong bit counter or column counter shows up in the data of the very next byte. It also breaks the fixed 8-cycle spacing, so the fault appears within one byte time. A stale page counter or a wrong snapped bound changes the number of bytes, moves the outLast flag, or lets a read address escape the region. Each of these is visible no later than the end of the update. A broken stall path shows as a byte that changes or vanishes while outReady is low, which is detected in the first cycle after the stall.

// File: rtl/pix_xpose_pkg.sv
package pix_xpose_pkg;

  // Per-read strobes handed from the read sequencer to the gather datapath
  typedef struct packed {
    logic       issue;      // a read slot is used this cycle
    logic       masked;     // row lies below the panel: bit forced to zero
    logic [2:0] bitSel;     // bit of the fetched byte holding the column
    logic [2:0] rowIdx;     // row within the page, equals the output bit
    logic       byteEnd;    // final row of this column byte
    logic       finalByte;  // final byte of the whole update
  } xpStrobe_t;

endpackage

// File: rtl/pix_xpose_ctrl.sv
module pix_xpose_ctrl
  import pix_xpose_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int ROW_W  = 7,
  parameter int ADDR_W = COL_W + ROW_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              stall,
  input  logic [COL_W-1:0]  rectWidth,
  input  logic [ROW_W-1:0]  rectTop,
  input  logic [ROW_W-1:0]  rectBottom,
  input  logic [ROW_W-1:0]  panelHeight,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  output xpStrobe_t         strobe
);
  localparam int LINE_W = COL_W - 2;
  localparam int PG_W   = ROW_W - 2;

  logic              active;
  logic [2:0]        kCnt;
  logic [COL_W-1:0]  colCnt;
  logic [PG_W-1:0]   pgCnt;
  logic [COL_W-1:0]  wReg;
  logic [LINE_W-1:0] lineLen;
  logic [PG_W-1:0]   pgTot;
  logic [ROW_W-1:0]  yTopR;
  logic [ROW_W-1:0]  hReg;

  // region snapping, evaluated on the start cycle
  logic [ROW_W-1:0] yTopC;
  logic [ROW_W:0]   yEndUp, yBotC, spanC, spanUp;
  logic [PG_W-1:0]  pagesC;
  logic [COL_W:0]   widthUp;
  logic [LINE_W-1:0] lineLenC;

  always_comb begin
    yTopC    = {rectTop[ROW_W-1:3], 3'b000};
    yEndUp   = ({1'b0, rectBottom} + (ROW_W+1)'(7)) & ~(ROW_W+1)'(7);
    yBotC    = (yEndUp > {1'b0, panelHeight}) ? {1'b0, panelHeight} : yEndUp;
    spanC    = (yBotC > {1'b0, yTopC}) ? yBotC - {1'b0, yTopC} : '0;
    spanUp   = spanC + (ROW_W+1)'(7);
    pagesC   = spanUp[ROW_W:3];
    widthUp  = {1'b0, rectWidth} + (COL_W+1)'(7);
    lineLenC = widthUp[COL_W:3];
  end

  // read slot for (page, column, row)
  logic [ROW_W:0]    rowRel, absRow;
  logic [ADDR_W-1:0] rowBase;
  logic              masked, lastCol, lastPg, issue;

  always_comb begin
    rowRel  = {pgCnt, kCnt};
    absRow  = rowRel + {1'b0, yTopR};
    masked  = absRow >= {1'b0, hReg};
    rowBase = ADDR_W'(rowRel) * ADDR_W'(lineLen);
    rdAddr  = rowBase + ADDR_W'(colCnt[COL_W-1:3]);
    lastCol = colCnt == wReg - COL_W'(1);
    lastPg  = pgCnt == pgTot - PG_W'(1);
    issue   = active && !stall;
    rdEn    = issue && !masked;
    strobe.issue     = issue;
    strobe.masked    = masked;
    strobe.bitSel    = colCnt[2:0];
    strobe.rowIdx    = kCnt;
    strobe.byteEnd   = kCnt == 3'd7;
    strobe.finalByte = (kCnt == 3'd7) && lastCol && lastPg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      kCnt    <= '0;
      colCnt  <= '0;
      pgCnt   <= '0;
      wReg    <= '0;
      lineLen <= '0;
      pgTot   <= '0;
      yTopR   <= '0;
      hReg    <= '0;
    end else if (start && !active) begin
      active  <= (rectWidth != '0) && (pagesC != '0);
      kCnt    <= '0;
      colCnt  <= '0;
      pgCnt   <= '0;
      wReg    <= rectWidth;
      lineLen <= lineLenC;
      pgTot   <= pagesC;
      yTopR   <= yTopC;
      hReg    <= panelHeight;
    end else if (issue) begin
      kCnt <= kCnt + 3'd1;
      if (kCnt == 3'd7) begin
        if (lastCol) begin
          colCnt <= '0;
          if (lastPg) active <= 1'b0;
          else        pgCnt  <= pgCnt + PG_W'(1);
        end else begin
          colCnt <= colCnt + COL_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pix_xpose_dp.sv
module pix_xpose_dp
  import pix_xpose_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  xpStrobe_t  strobe,
  input  logic [7:0] rdData,
  input  logic       outReady,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outLast
);
  xpStrobe_t  pipeQ;     // strobes aligned with returning memory data
  logic [7:0] gather;
  logic       bitVal;

  always_comb bitVal = pipeQ.issue && !pipeQ.masked && rdData[pipeQ.bitSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeQ    <= '0;
      gather   <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outLast  <= 1'b0;
    end else begin
      pipeQ <= strobe;
      if (pipeQ.issue) begin
        if (pipeQ.byteEnd) begin
          outData <= gather | {bitVal, 7'b0};
          outLast <= pipeQ.finalByte;
          gather  <= '0;
        end else begin
          gather[pipeQ.rowIdx] <= bitVal;
        end
      end
      if (pipeQ.issue && pipeQ.byteEnd) outValid <= 1'b1;
      else if (outReady)                outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/pix_page_xpose.sv
module pix_page_xpose
  import pix_xpose_pkg::*;
#(
  parameter  int COL_W  = 8,
  parameter  int ROW_W  = 7,
  localparam int ADDR_W = COL_W + ROW_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [COL_W-1:0]  rectWidth,
  input  logic [ROW_W-1:0]  rectTop,
  input  logic [ROW_W-1:0]  rectBottom,
  input  logic [ROW_W-1:0]  panelHeight,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData,
  output logic              outLast
);
  xpStrobe_t strobe;
  logic      stall;

  always_comb stall = outValid && !outReady;

  pix_xpose_ctrl #(.COL_W(COL_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stall(stall),
    .rectWidth(rectWidth), .rectTop(rectTop), .rectBottom(rectBottom),
    .panelHeight(panelHeight), .rdEn(rdEn), .rdAddr(rdAddr), .strobe(strobe)
  );

  pix_xpose_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(rdData),
    .outReady(outReady), .outValid(outValid), .outData(outData), .outLast(outLast)
  );

endmodule

// File: rtl/pix_page_xpose_chk.sv
module pix_page_xpose_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       rdEn,
  input logic       outValid,
  input logic       outReady,
  input logic       outLast,
  input logic [7:0] outData
);
  // R8: a refused byte stays put
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));

  // R8: no fetch while the output slot is blocked
  p_no_read_blocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !rdEn);

  // R7: bytes are spaced, so a taken byte is never followed at once by another
  p_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady |=> !outValid);

  // R6: after the final byte is taken the sequencer is quiet
  p_last_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast && !start |=> !rdEn);

endmodule

bind pix_page_xpose pix_page_xpose_chk i_chk (.*);

// File: tb/test_pix_page_xpose.sv
module test_pix_page_xpose;
  localparam int COL_W  = 8;
  localparam int ROW_W  = 7;
  localparam int ADDR_W = COL_W + ROW_W - 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [COL_W-1:0]  rectWidth = '0;
  logic [ROW_W-1:0]  rectTop = '0, rectBottom = '0, panelHeight = '0;
  logic              rdEn;
  logic [ADDR_W-1:0] rdAddr;
  logic [7:0]        rdData = '0;
  logic              outValid;
  logic              outReady = 1'b1;
  logic [7:0]        outData;
  logic              outLast;

  always #10 clk = ~clk;  // 50 MHz

  pix_page_xpose #(.COL_W(COL_W), .ROW_W(ROW_W)) i_pix_page_xpose (
    .clk(clk), .rstN(rstN), .start(start), .rectWidth(rectWidth),
    .rectTop(rectTop), .rectBottom(rectBottom), .panelHeight(panelHeight),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outLast(outLast)
  );

  logic [7:0] mem [0:511];
  always @(posedge clk) if (rdEn) rdData <= mem[rdAddr[8:0]];

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    expQ[$];
  bit    lastQ[$];
  int    rdLimit = 0;
  string tag = "R3";
  bit    readyMode = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  int    startCyc = 0, lastAcc = 0, strays = 0;
  bit    firstPending = 1'b0;
  bit    holdPrev = 1'b0;
  logic [7:0] prevData = '0;
  logic  prevLast = 1'b0;

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  // reference monitor, compared every clock
  always @(negedge clk) begin
    int  e;
    bit  l;
    if (rstN) begin
      if (readyMode) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        outReady = lfsr[0] | lfsr[2];
      end else begin
        outReady = 1'b1;
      end
      if (holdPrev)
        chk(outData == prevData && outLast == prevLast, "R8", "held byte",
            int'(outData), int'(prevData));
      if (rdEn)
        chk(int'(rdAddr) < rdLimit, "R5", "read address", int'(rdAddr), rdLimit);
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          strays++;
          chk(1'b0, "R9/R10", "unexpected byte", int'(outData), -1);
        end else begin
          e = expQ.pop_front();
          l = lastQ.pop_front();
          chk(int'(outData) == e, tag, "column byte", int'(outData), e);
          chk(outLast == l, "R6", "last flag", int'(outLast), int'(l));
          if (!readyMode) begin
            if (firstPending) chk(cyc - startCyc == 10, "R7", "first latency", cyc - startCyc, 10);
            else              chk(cyc - lastAcc == 8, "R7", "byte spacing", cyc - lastAcc, 8);
          end
          firstPending = 1'b0;
          lastAcc = cyc;
        end
      end
      holdPrev = outValid && !outReady;
      prevData = outData;
      prevLast = outLast;
    end
  end

  task automatic launch(input int w, input int y1, input int y2, input int h, input string t);
    int yTop, yEnd, yBot, pages, ll, b, a;
    yTop  = (y1 / 8) * 8;
    yEnd  = ((y2 + 7) / 8) * 8;
    yBot  = (yEnd > h) ? h : yEnd;
    pages = (yBot > yTop) ? (yBot - yTop + 7) / 8 : 0;
    ll    = (w + 7) / 8;
    if (w == 0) pages = 0;
    rdLimit = (pages == 0) ? 0 : (yBot - yTop) * ll;
    for (int pg = 0; pg < pages; pg++)
      for (int j = 0; j < w; j++) begin
        b = 0;
        for (int k = 0; k < 8; k++)
          if (yTop + 8 * pg + k < h) begin
            a = (8 * pg + k) * ll + j / 8;
            if (mem[a][j % 8]) b = b | (1 << k);
          end
        expQ.push_back(b);
        lastQ.push_back(pg == pages - 1 && j == w - 1);
      end
    @(negedge clk);
    tag = t;
    rectWidth = COL_W'(w);
    rectTop = ROW_W'(y1);
    rectBottom = ROW_W'(y2);
    panelHeight = ROW_W'(h);
    start = 1'b1;
    startCyc = cyc;
    firstPending = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    for (int a = 0; a < 512; a++) mem[a] = 8'((a * 37 + 11) ^ (a >> 2));
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R11", "outValid after reset", int'(outValid), 0);
    chk(rdEn == 1'b0, "R11", "rdEn after reset", int'(rdEn), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    launch(16, 0, 16, 64, "R1");    drain();   // bit order, two pages
    launch(13, 5, 11, 64, "R2");    drain();   // odd width, line length 2
    launch(24, 10, 27, 64, "R4");   drain();   // snapping to 8..32
    launch(20, 8, 30, 20, "R5");    drain();   // partial last page
    launch(40, 0, 64, 64, "R3");    drain();   // full-height ordering

    readyMode = 1'b1;
    launch(10, 0, 24, 24, "R8");    drain();   // random back-pressure
    readyMode = 1'b0;
    repeat (2) @(negedge clk);

    s0 = strays;                               // R9: restart while busy
    launch(16, 0, 16, 64, "R9");
    repeat (20) @(negedge clk);
    rectWidth = 8'd5; rectTop = 7'd32; rectBottom = 7'd40;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    chk(strays == s0, "R9", "bytes after ignored start", strays - s0, 0);

    s0 = strays;                               // R10: empty regions
    launch(0, 0, 16, 64, "R10");    drain();
    launch(16, 48, 60, 40, "R10");  drain();
    launch(16, 40, 40, 64, "R10");  drain();
    chk(strays == s0, "R10", "bytes from empty region", strays - s0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule